// File: doc/BRIEF.md
# Prescaled Countdown Timer with Reload

This block counts a 32-bit value down to zero at a rate set by a programmable clock divider. It then raises a one-cycle interrupt request that carries a vector. Software programs it through three kinds of access:

- a write strobe for the start value;
- a write strobe for the divider setting;
- a set of level inputs that describe how expiry is handled: the vector, a mask flag and a repeat flag.

The start value, the live count and the divider setting can be read back at any time.

A write of the start value always restarts the block. A nonzero value loads the live count, clears the divider phase and begins counting. A zero value parks the timer. When the count expires, the repeat flag chooses the next step: with the flag clear the timer stops at zero, and with it set the count reloads from the start value and keeps running. The mask flag only gates the interrupt pulse. Counting, reloading and stopping carry on exactly the same whether the mask is set or clear.

Top module: `cdt_timer`

## Requirements
- R1: The divider register keeps only bits 3, 1 and 0 of a write. Bit 2 and every other bit read back as 0, so `rd_div` equals the written value AND 4'b1011 from the cycle after the write.
- R2: The divide code is {bit3, bit1, bit0}. Code 7 divides by 1, and any other code c divides by 2<<c (2 up to 128). While running, the live count drops by one every F clocks, where F is the divide factor. The first drop comes F clocks after the start-value write.
- R3: A write of a nonzero start value N sets `rd_init` and `rd_cur` to N in the next cycle and restarts the divider phase. This holds even if the timer is already counting.
- R4: A write of a start value of 0 stops the timer. After it, `rd_cur` reads 0, stays 0, and no interrupt pulse follows.
- R5: In one-shot mode (repeat flag = 0), the live count reaches 0 exactly N·F clocks after the start write. It holds 0 from then on and never wraps.
- R6: In periodic mode (repeat flag = 1), the count reloads to N in place of 0. The timer then expires every N·F clocks.
- R7: Each expiry with the mask flag at 0 gives `irq_pulse` high for exactly the one cycle in which the count first shows its post-expiry value. `irq_vector` shows the vector input sampled at expiry. With the mask flag at 1, no pulse is produced.
- R8: After reset, the start value, live count and divider register all read 0 (divide by 2), the timer is stopped, and `irq_pulse` is low.
- R9: A change of the divider while counting takes effect at once. If the divider phase has already passed the new limit, the next drop comes one clock after the divider write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_init | input | 1 | Write strobe for the start value |
| cfg_init_data | input | CNT_W | Start value to write |
| cfg_we_div | input | 1 | Write strobe for the divider register |
| cfg_div_data | input | 4 | Divider value to write |
| lvt_vector | input | VEC_W | Vector delivered on expiry |
| lvt_mask | input | 1 | 1 suppresses the interrupt pulse |
| lvt_periodic | input | 1 | 1 selects reload on expiry, 0 selects one-shot |
| rd_init | output | CNT_W | Stored start value |
| rd_cur | output | CNT_W | Live count |
| rd_div | output | 4 | Divider register readback |
| irq_pulse | output | 1 | One-cycle edge-type interrupt request |
| irq_vector | output | VEC_W | Vector of the latest expiry |

## Verification
Every result is due one clock edge after its cause. A register write shows on the read ports in the next cycle. A drop of the live count shows F edges after the start write, and then every F edges. An expiry shows on the count and on `irq_pulse` at the same edge, N·F edges after the start write.

The bench drives inputs on the falling edge and checks on every following falling edge. It counts edges since the last start write, k. From k alone it computes the expected count as N − ⌊k/F⌋: clamped at 0 in one-shot mode, or taken modulo N in periodic mode. It expects a pulse exactly when k is a multiple of N·F. The mid-run divider change is checked edge by edge from the divider write onward.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int DIV_W   = 4;
  localparam int CODE_W  = 3;
  localparam int PRE_W   = 8;
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'b1011;

  typedef struct packed {
    logic       periodic;
    logic       mask;
  } expiry_ctl_t;

  // Effective divide code gathered from the writable bits.
  function automatic logic [CODE_W-1:0] div_code(input logic [DIV_W-1:0] r);
    return {r[3], r[1], r[0]};
  endfunction

  // Divide factor for a code: all-ones selects 1, otherwise 2 << code.
  function automatic logic [PRE_W-1:0] div_factor(input logic [CODE_W-1:0] c);
    logic [PRE_W-1:0] f;
    if (c == {CODE_W{1'b1}}) f = PRE_W'(1);
    else                     f = PRE_W'(2) << c;
    return f;
  endfunction

  // Phase limit of the prescaler: factor minus one.
  function automatic logic [PRE_W-1:0] phase_limit(input logic [DIV_W-1:0] r);
    return div_factor(div_code(r)) - PRE_W'(1);
  endfunction
endpackage

// File: rtl/cdt_divcfg.sv
module cdt_divcfg
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DIV_W-1:0] wdata,
  output logic [DIV_W-1:0] rd,
  output logic [PRE_W-1:0] limit
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  div_q <= '0;
    else if (we) div_q <= wdata & DIV_KEEP;
  end

  assign rd    = div_q;
  assign limit = phase_limit(div_q);
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  // A phase past the limit (after a divider change) ticks at once.
  assign tick = (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else              phase_q <= phase_q + PRE_W'(1);
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] init_q,
  output logic [CNT_W-1:0] cur_q,
  output logic             active_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] after_tick(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] ini,
                                                  input logic rep);
    logic [CNT_W-1:0] n;
    if (c != ONE) n = c - ONE;
    else if (rep) n = ini;
    else          n = '0;
    return n;
  endfunction

  assign expire = active_q && tick && !load && (cur_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q   <= '0;
      cur_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      init_q   <= load_val;
      cur_q    <= load_val;
      active_q <= |load_val;
    end else if (active_q && tick) begin
      cur_q <= after_tick(cur_q, init_q, periodic);
      if (expire && !periodic) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             mask,
  input  logic [VEC_W-1:0] vector,
  output logic             pulse,
  output logic [VEC_W-1:0] vec_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      vec_q <= '0;
    end else begin
      pulse <= expire && !mask;
      if (expire) vec_q <= vector;
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_init,
  input  logic [CNT_W-1:0] cfg_init_data,
  input  logic             cfg_we_div,
  input  logic [DIV_W-1:0] cfg_div_data,
  input  logic [VEC_W-1:0] lvt_vector,
  input  logic             lvt_mask,
  input  logic             lvt_periodic,
  output logic [CNT_W-1:0] rd_init,
  output logic [CNT_W-1:0] rd_cur,
  output logic [DIV_W-1:0] rd_div,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector
);
  expiry_ctl_t      ctl;
  logic [PRE_W-1:0] limit_w;
  logic             raw_tick_w;
  logic             tick_w;
  logic             active_w;
  logic             expire_w;

  assign ctl.periodic = lvt_periodic;
  assign ctl.mask     = lvt_mask;

  cdt_divcfg u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we_div),
    .wdata (cfg_div_data),
    .rd    (rd_div),
    .limit (limit_w)
  );

  cdt_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_we_init),
    .limit   (limit_w),
    .tick    (raw_tick_w)
  );

  assign tick_w = raw_tick_w && active_w;

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_we_init),
    .load_val (cfg_init_data),
    .tick     (tick_w),
    .periodic (ctl.periodic),
    .init_q   (rd_init),
    .cur_q    (rd_cur),
    .active_q (active_w),
    .expire   (expire_w)
  );

  cdt_irq #(.VEC_W(VEC_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire_w),
    .mask   (ctl.mask),
    .vector (lvt_vector),
    .pulse  (irq_pulse),
    .vec_q  (irq_vector)
  );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we_init,
  input logic [CNT_W-1:0] cfg_init_data,
  input logic             cfg_we_div,
  input logic [3:0]       cfg_div_data,
  input logic             lvt_mask,
  input logic             lvt_periodic,
  input logic [CNT_W-1:0] rd_init,
  input logic [CNT_W-1:0] rd_cur,
  input logic [3:0]       rd_div,
  input logic             irq_pulse,
  input logic             tick_w,
  input logic             expire_w,
  input logic             active_w
);
  p_div_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_div |=> rd_div == ($past(cfg_div_data) & 4'b1011));

  p_drop_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && !cfg_we_init && rd_cur > CNT_W'(1)) |=> rd_cur == $past(rd_cur) - CNT_W'(1));

  p_still_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_w && !cfg_we_init) |=> $stable(rd_cur));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_init |=> (rd_cur == $past(cfg_init_data)) && (rd_init == $past(cfg_init_data)));

  p_zero_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_init && cfg_init_data == '0) |=> !active_w);

  p_oneshot_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !lvt_periodic) |=> !active_w && rd_cur == '0);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && lvt_periodic) |=> active_w && rd_cur == $past(rd_init));

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(expire_w && !lvt_mask));

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && lvt_mask) |=> !irq_pulse);
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we_init   (cfg_we_init),
  .cfg_init_data (cfg_init_data),
  .cfg_we_div    (cfg_we_div),
  .cfg_div_data  (cfg_div_data),
  .lvt_mask      (lvt_mask),
  .lvt_periodic  (lvt_periodic),
  .rd_init       (rd_init),
  .rd_cur        (rd_cur),
  .rd_div        (rd_div),
  .irq_pulse     (irq_pulse),
  .tick_w        (tick_w),
  .expire_w      (expire_w),
  .active_w      (active_w)
);

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we_init = 1'b0;
  logic [CW-1:0] cfg_init_data = '0;
  logic          cfg_we_div = 1'b0;
  logic [3:0]    cfg_div_data = '0;
  logic [VW-1:0] lvt_vector = '0;
  logic          lvt_mask = 1'b0;
  logic          lvt_periodic = 1'b0;
  logic [CW-1:0] rd_init, rd_cur;
  logic [3:0]    rd_div;
  logic          irq_pulse;
  logic [VW-1:0] irq_vector;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_timer #(.CNT_W(CW), .VEC_W(VW)) dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int factor_of(input int code);
    return (code == 7) ? 1 : (1 << (code + 1));
  endfunction

  task automatic wr_div(input logic [3:0] v);
    cfg_we_div = 1'b1; cfg_div_data = v;
    @(negedge clk);
    cfg_we_div = 1'b0;
  endtask

  task automatic wr_init(input logic [CW-1:0] v);
    cfg_we_init = 1'b1; cfg_init_data = v;
    @(negedge clk);
    cfg_we_init = 1'b0;
  endtask

  // Start value n, divide factor f; checks count and pulse every edge.
  task automatic run(input int n, input int f, input bit rep, input bit msk,
                     input logic [VW-1:0] vec, input int edges, input string req);
    int period;
    period = n * f;
    lvt_periodic = rep; lvt_mask = msk; lvt_vector = vec;
    wr_init(CW'(n));
    chk(rd_cur == CW'(n) && rd_init == CW'(n), "R3 load", rd_cur, n);
    for (int k = 1; k <= edges; k++) begin
      int ec;
      bit ep;
      @(negedge clk);
      if (rep) begin
        ec = n - ((k / f) % n);
        ep = !msk && (k % period == 0);
      end else begin
        ec = (k < period) ? n - k / f : 0;
        ep = !msk && (k == period);
      end
      chk(rd_cur == CW'(ec), req, rd_cur, ec);
      chk(irq_pulse == ep, "R7 pulse", irq_pulse, ep);
      if (ep) chk(irq_vector == vec, "R7 vector", irq_vector, vec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(rd_init == 0 && rd_cur == 0, "R8 counts", rd_cur, 0);
    chk(rd_div == 0, "R8 div", rd_div, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!irq_pulse && rd_cur == 0, "R8 idle", irq_pulse, 0);
    end
    // R1 divider readback sweep
    for (int v = 0; v < 16; v++) begin
      wr_div(4'(v));
      chk(rd_div == (4'(v) & 4'b1011), "R1 readback", rd_div, v & 11);
    end
    // R2/R5 one-shot per code, R2/R6 periodic per code (bit 2 set, ignored)
    for (int c = 0; c < 8; c++) begin
      logic [2:0] cc;
      int f;
      cc = 3'(c);
      f = factor_of(c);
      wr_div({cc[2], 1'b1, cc[1], cc[0]});
      run(3, f, 1'b0, 1'b0, 8'(8'h30 + c), 3 * f + 4, "R5 oneshot R2");
      run(2, f, 1'b1, 1'b0, 8'(8'h50 + c), 4 * f + 2, "R6 periodic R2");
    end
    // R7 masked periodic: count still reloads, no pulse
    wr_div(4'b0000);
    run(3, 2, 1'b1, 1'b1, 8'hA5, 20, "R7 masked R6");
    // R6 periodic with start value 1 at divide-by-1: pulse every edge
    wr_div(4'b1011);
    run(1, 1, 1'b1, 1'b0, 8'h11, 6, "R6 n1");
    // R3 restart mid-run
    wr_div(4'b0000);
    run(4, 2, 1'b0, 1'b0, 8'h21, 5, "R3 partial");
    run(6, 2, 1'b0, 1'b0, 8'h22, 16, "R3 restart");
    // R4 zero stops
    wr_div(4'b1011);
    run(10, 1, 1'b0, 1'b0, 8'h33, 3, "R4 pre");
    wr_init('0);
    chk(rd_cur == 0 && rd_init == 0, "R4 zero", rd_cur, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(rd_cur == 0 && !irq_pulse, "R4 stopped", rd_cur, 0);
    end
    // R9 divider change while running
    lvt_periodic = 1'b0; lvt_mask = 1'b0; lvt_vector = 8'h7E;
    wr_div(4'b1010);
    wr_init(CW'(5));
    repeat (10) @(negedge clk);
    chk(rd_cur == 5, "R9 slow", rd_cur, 5);
    wr_div(4'b1011);
    chk(rd_cur == 5, "R9 at write", rd_cur, 5);
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk);
      chk(rd_cur == CW'(5 - j), "R9 fast", rd_cur, 5 - j);
      chk(irq_pulse == (j == 5), "R9 pulse R7", irq_pulse, j == 5);
    end
    @(negedge clk);
    chk(rd_cur == 0 && !irq_pulse, "R5 hold", rd_cur, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule